// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt events from up to `NUM_SRC` sources and decides which one the processor should take next. Each source has a pending flag, an enable bit, a three-bit priority level and a two-bit subpriority, all held in a small register file. The register file has a single-cycle read/write port. From the pending, enabled and non-zero-priority sources, the controller picks one winner. It then offers that winner's vector number, priority level and shadow register set number to the processor, together with a registered request line.

A processor that takes the request pulses `irq_ack`. The controller then records the taken level as the level now in service. Only a strictly higher level can raise a new request after that. When the service routine finishes, it clears the source flag through the register port and pulses `irq_eoi`. The controller then drops back to the level that was in service before. A configuration bit chooses between a common vector (zero) for all sources and a per-source vector equal to the source index.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset all flags, enables, priorities, subpriorities, the mode bit, the shadow-set map and the in-service levels are zero, and `irq_req` is low.
- R2: Register index is `reg_addr[ADDR_W-1:2]`: 0 = mode (bit 0 selects per-source vectors), 1 = shadow-set map (level L in bits 4L-1..4L-4), 2..2+FW-1 = flags (32 sources per word), next FW = enables, then one word per four sources (source 4w+k: priority in bits 8k+2..8k, subpriority in bits 8k+4..8k+3, other bits read 0). `reg_addr[1:0]` selects the write style: 0 replace, 1 clear the bits set in data, 2 set them, 3 invert them. A read returns the stored value.
- R3: A pulse on `irq_evt[i]` sets flag i at that clock edge, and the flag stays set until software clears it.
- R4: A source with its enable bit at 0 never causes a request.
- R5: A source with priority 0 never causes a request, even when it is enabled and flagged.
- R6: Among qualifying sources, the highest priority level wins.
- R7: At equal priority, the higher subpriority wins.
- R8: At equal priority and subpriority, the lowest source index wins.
- R9: With the mode bit at 1, `irq_vec` is the winner's index. With the mode bit at 0, it is 0.
- R10: `irq_req` rises one clock edge after the edge that stored the qualifying flag, enable or priority.
- R11: `irq_req` is asserted only when the winner's level is strictly above the level in service. An equal or lower level does not request.
- R12: `irq_ack` while `irq_req` is high makes `irq_lvl` the level in service and drops `irq_req` at that edge. `irq_eoi` retires the level in service and restores the previous one.
- R13: `irq_srs` is the shadow-set number that the map assigns to the winner's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_evt | input | NUM_SRC | Per-source event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register index and write style |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Interrupt request to processor |
| irq_vec | output | VEC_W | Vector number of the winner |
| irq_lvl | output | 3 | Priority level of the winner |
| irq_srs | output | 4 | Shadow register set for the winner's level |
| irq_ack | input | 1 | Processor takes the offered interrupt |
| irq_eoi | input | 1 | End of the interrupt in service |

## Verification
The bench targets the three-tier tie-break with sources that share a level and a subpriority. A design that scanned from the top index, or that compared level only, would name the wrong vector. It sets up a priority-0 source whose subpriority is non-zero: a controller that compared the combined key without gating on the level would raise a request for it. The nesting test offers an equal-level request while one is in service, which must stay silent. It then retires the higher level while lower ones are still pending, so a controller that forgot the previous level would either request at once or never request again. The bench also samples the request one edge after a flag write, to catch an output that is combinational or late by a cycle.

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NUM_SRC = 64,
  localparam int VEC_W  = $clog2(NUM_SRC),
  localparam int FW     = NUM_SRC / 32,
  localparam int PW     = NUM_SRC / 4,
  localparam int NREG   = 2 + 2 * FW + PW,
  localparam int ADDR_W = $clog2(NREG) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_evt,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [2:0]         irq_lvl,
  output logic [3:0]         irq_srs,
  input  logic               irq_ack,
  input  logic               irq_eoi
);
  localparam int FLG0 = 2;
  localparam int ENA0 = 2 + FW;
  localparam int PRI0 = 2 + 2 * FW;

  logic               mvec_q;
  logic [27:0]        srs_q;
  logic [NUM_SRC-1:0] flag_q, en_q, flag_nxt;
  logic [2:0]         prio_q [NUM_SRC];
  logic [1:0]         sub_q  [NUM_SRC];
  logic [7:1]         act_q, act_nxt;
  logic [2:0]         cur_lvl;
  logic [31:0]        wr_word, srs_ext;
  logic [4:0]         best_key;
  logic [VEC_W-1:0]   best_idx;
  int                 idx;

  assign idx     = 32'(reg_addr[ADDR_W-1:2]);
  assign srs_ext = {srs_q, 4'b0};

  always_comb begin
    reg_rdata = '0;
    if (idx == 0) reg_rdata[0] = mvec_q;
    else if (idx == 1) reg_rdata[27:0] = srs_q;
    else if (idx < ENA0) reg_rdata = flag_q[32*(idx-FLG0) +: 32];
    else if (idx < PRI0) reg_rdata = en_q[32*(idx-ENA0) +: 32];
    else if (idx < NREG)
      for (int k = 0; k < 4; k++)
        reg_rdata[8*k +: 5] = {sub_q[4*(idx-PRI0)+k], prio_q[4*(idx-PRI0)+k]};
  end

  always_comb
    case (reg_addr[1:0])
      2'd0:    wr_word = reg_wdata;
      2'd1:    wr_word = reg_rdata & ~reg_wdata;
      2'd2:    wr_word = reg_rdata | reg_wdata;
      default: wr_word = reg_rdata ^ reg_wdata;
    endcase

  always_comb begin
    flag_nxt = flag_q;
    if (reg_wr && idx >= FLG0 && idx < ENA0) flag_nxt[32*(idx-FLG0) +: 32] = wr_word;
    flag_nxt = flag_nxt | irq_evt;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mvec_q <= 1'b0;
      srs_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        prio_q[i] <= '0;
        sub_q[i]  <= '0;
      end
    end else begin
      flag_q <= flag_nxt;
      if (reg_wr) begin
        if (idx == 0) mvec_q <= wr_word[0];
        if (idx == 1) srs_q <= wr_word[27:0];
        if (idx >= ENA0 && idx < PRI0) en_q[32*(idx-ENA0) +: 32] <= wr_word;
        if (idx >= PRI0 && idx < NREG)
          for (int k = 0; k < 4; k++) begin
            prio_q[4*(idx-PRI0)+k] <= wr_word[8*k +: 3];
            sub_q[4*(idx-PRI0)+k]  <= wr_word[8*k+3 +: 2];
          end
      end
    end

  always_comb begin
    best_key = '0;
    best_idx = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (flag_q[i] && en_q[i] && prio_q[i] != 3'd0 && {prio_q[i], sub_q[i]} > best_key) begin
        best_key = {prio_q[i], sub_q[i]};
        best_idx = VEC_W'(i);
      end
  end

  always_comb begin
    cur_lvl = '0;
    for (int l = 1; l < 8; l++) if (act_q[l]) cur_lvl = 3'(l);
  end

  always_comb begin
    act_nxt = act_q;
    if (irq_eoi && cur_lvl != 3'd0) act_nxt[cur_lvl] = 1'b0;
    if (irq_ack && irq_req) act_nxt[irq_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q   <= '0;
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= '0;
      irq_srs <= '0;
    end else begin
      act_q   <= act_nxt;
      irq_req <= (best_key[4:2] > cur_lvl) && !(irq_ack && irq_req);
      irq_vec <= mvec_q ? best_idx : '0;
      irq_lvl <= best_key[4:2];
      irq_srs <= srs_ext[4*best_key[4:2] +: 4];
    end

  assert_evt_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(irq_evt)) == $past(irq_evt)));
  assert_lvl_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_lvl != 3'd0);
  assert_common_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !$past(mvec_q)) |-> irq_vec == '0);
  assert_strict_preempt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_lvl > $past(cur_lvl));
  assert_ack_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (cur_lvl == $past(irq_lvl) && !irq_req));
  assert_eoi_pops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_eoi && cur_lvl != 3'd0 && !irq_ack) |=> $countones(act_q) == $countones($past(act_q)) - 1);
endmodule

// File: tb/prio_vec_intc_test.sv
`timescale 1ns/1ps
module prio_vec_intc_test;
  localparam int N = 64;
  localparam int FLG0 = 2, ENA0 = 4, PRI0 = 6;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_evt = '0;
  logic reg_wr = 0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_req, irq_ack = 0, irq_eoi = 0;
  logic [5:0] irq_vec;
  logic [2:0] irq_lvl;
  logic [3:0] irq_srs;

  prio_vec_intc uut (.clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl), .irq_srs(irq_srs), .irq_ack(irq_ack), .irq_eoi(irq_eoi));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  bit [N-1:0] m_flag, m_en;
  bit [2:0] m_prio [N];
  bit [1:0] m_sub [N];
  bit m_mvec;
  bit [3:0] m_srs [8];
  bit [7:0] m_act;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] apply(bit [31:0] old, bit [31:0] d, int op);
    case (op)
      0: return d;
      1: return old & ~d;
      2: return old | d;
      default: return old ^ d;
    endcase
  endfunction

  function automatic int cur();
    int c = 0;
    for (int l = 1; l < 8; l++) if (m_act[l]) c = l;
    return c;
  endfunction

  function automatic void expect_win(output bit f, output int w, output int lv);
    f = 0; w = 0; lv = 0;
    for (int p = 7; p >= 1 && !f; p--)
      for (int s = 3; s >= 0 && !f; s--)
        for (int i = 0; i < N && !f; i++)
          if (m_flag[i] && m_en[i] && m_prio[i] == p && m_sub[i] == s) begin
            f = 1; w = i; lv = p;
          end
  endfunction

  task automatic wr(int idx, int op, bit [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 7'(idx * 4 + op); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int idx, output bit [31:0] d);
    @(negedge clk);
    reg_addr = 7'(idx * 4);
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic flags(int w, int op, bit [31:0] d);
    m_flag[32*w +: 32] = apply(m_flag[32*w +: 32], d, op);
    wr(FLG0 + w, op, d);
  endtask

  task automatic enables(int w, bit [31:0] d);
    m_en[32*w +: 32] = d;
    wr(ENA0 + w, 0, d);
  endtask

  task automatic prio_word(int w, bit [31:0] d);
    for (int k = 0; k < 4; k++) begin
      m_prio[4*w+k] = d[8*k +: 3];
      m_sub[4*w+k] = d[8*k+3 +: 2];
    end
    wr(PRI0 + w, 0, d);
  endtask

  task automatic set_src(int s, int p, int sb);
    bit [31:0] d = '0;
    m_prio[s] = 3'(p); m_sub[s] = 2'(sb);
    for (int k = 0; k < 4; k++) d[8*k +: 5] = {m_sub[4*(s/4)+k], m_prio[4*(s/4)+k]};
    wr(PRI0 + s / 4, 0, d);
  endtask

  task automatic mode(bit mv);
    m_mvec = mv;
    wr(0, 0, {31'b0, mv});
  endtask

  task automatic srs_map(bit [27:0] d);
    for (int l = 1; l < 8; l++) m_srs[l] = d[4*l-4 +: 4];
    wr(1, 0, {4'b0, d});
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    m_act[irq_lvl] = 1'b1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic eoi();
    @(negedge clk); irq_eoi = 1;
    if (cur() != 0) m_act[cur()] = 1'b0;
    @(negedge clk); irq_eoi = 0;
  endtask

  task automatic chk_out(string tag);
    bit f; int w, lv;
    bit er;
    expect_win(f, w, lv);
    er = f && lv > cur();
    check({tag, " req"}, {31'b0, irq_req}, {31'b0, er});
    if (er) begin
      check({tag, " vec"}, {26'b0, irq_vec}, m_mvec ? 32'(w) : 32'd0);
      check({tag, " lvl"}, {29'b0, irq_lvl}, 32'(lv));
      check({tag, " srs R13"}, {28'b0, irq_srs}, {28'b0, m_srs[lv]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [31:0] d;
    void'($urandom(32'd2024));
    m_flag = '0; m_en = '0; m_mvec = 0; m_act = '0;
    for (int i = 0; i < N; i++) begin m_prio[i] = 0; m_sub[i] = 0; end
    for (int l = 0; l < 8; l++) m_srs[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 req", {31'b0, irq_req}, 0);
    rd(FLG0, d); check("R1 flags", d, 0);
    rd(PRI0 + 3, d); check("R1 prio", d, 0);

    // R2 access styles
    flags(0, 0, 32'hF0F0_00FF); rd(FLG0, d); check("R2 replace", d, m_flag[31:0]);
    flags(0, 2, 32'h0F00_0000); rd(FLG0, d); check("R2 set", d, 32'hFFF0_00FF);
    flags(0, 1, 32'h0000_000F); rd(FLG0, d); check("R2 clear", d, 32'hFFF0_00F0);
    flags(0, 3, 32'hFFFF_FFFF); rd(FLG0, d); check("R2 invert", d, 32'h000F_FF0F);
    prio_word(2, 32'hFFFF_FFFF); rd(PRI0 + 2, d); check("R2 prio fields", d, 32'h1F1F_1F1F);
    prio_word(2, 0);
    flags(0, 0, 0);
    check("R4 no enable no req", {31'b0, irq_req}, 0);

    // R3 event sets flag, stays
    @(negedge clk); irq_evt[37] = 1; @(negedge clk); irq_evt = '0; m_flag[37] = 1;
    repeat (3) @(negedge clk);
    rd(FLG0 + 1, d); check("R3 event flag", d, 32'h20);
    flags(1, 1, 32'h20); rd(FLG0 + 1, d); check("R3 sw clear", d, 0);

    // R10 request timing
    srs_map(28'h7654321);
    set_src(5, 4, 1);
    enables(0, 32'h0000_0020);
    flags(0, 2, 32'h20);
    check("R10 not yet", {31'b0, irq_req}, 0);
    settle(); chk_out("R10 one edge later");

    // R4 / R5
    flags(0, 1, 32'h20); settle();
    set_src(6, 0, 3); enables(0, 32'h40); flags(0, 2, 32'h40); settle(); settle();
    check("R5 prio zero", {31'b0, irq_req}, 0);
    set_src(7, 6, 0); flags(0, 2, 32'h80); settle();
    check("R4 disabled source", {31'b0, irq_req}, 0);
    flags(0, 0, 0); enables(0, 0); settle();

    // R6 R7 R8 ordering, R9 mode
    mode(1);
    set_src(10, 3, 3); set_src(20, 5, 0);
    enables(0, 32'hFFFF_FFFF); enables(1, 32'hFFFF_FFFF);
    flags(0, 2, (32'h1 << 10) | (32'h1 << 20)); settle();
    chk_out("R6 level"); check("R6 vec", {26'b0, irq_vec}, 20);
    set_src(30, 5, 2); flags(0, 2, 32'h1 << 30); settle();
    chk_out("R7 sub"); check("R7 vec", {26'b0, irq_vec}, 30);
    set_src(25, 5, 2); flags(0, 2, 32'h1 << 25); settle();
    chk_out("R8 index"); check("R8 vec", {26'b0, irq_vec}, 25);
    mode(0); settle();
    chk_out("R9 common"); check("R9 vec zero", {26'b0, irq_vec}, 0);
    mode(1); settle();
    check("R9 own vec", {26'b0, irq_vec}, 25);

    // R11 R12 R13 nesting
    ack();
    check("R12 req drops on ack", {31'b0, irq_req}, 0);
    settle(); chk_out("R12 in service 5");
    set_src(40, 5, 3); flags(1, 2, 32'h100); settle();
    check("R11 equal level silent", {31'b0, irq_req}, 0);
    set_src(41, 7, 0); flags(1, 2, 32'h200); settle();
    chk_out("R11 higher preempts");
    check("R13 srs level7", {28'b0, irq_srs}, 7);
    ack(); settle();
    flags(1, 1, 32'h200); eoi(); settle();
    check("R12 restored level 5", {31'b0, irq_req}, 0);
    chk_out("R12 after first eoi");
    eoi(); settle();
    chk_out("R12 back to idle");
    check("R12 vec after idle", {26'b0, irq_vec}, 40);

    // random mix, nothing in service
    for (int it = 0; it < 60; it++) begin
      for (int w = 0; w < N / 4; w++) prio_word(w, $urandom() & 32'h1F1F_1F1F);
      for (int w = 0; w < N / 32; w++) enables(w, $urandom());
      for (int w = 0; w < N / 32; w++) flags(w, 0, $urandom() & $urandom() & $urandom());
      mode(1'($urandom()));
      srs_map(28'($urandom()));
      settle();
      chk_out("R6 R7 R8 R9 R4 R5 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule